// File: doc/BRIEF.md
# Two-Slot Outstanding Miss Tracker

This block sits beside a primary data cache and keeps a record of the misses that are still waiting for their line to come back from the second-level cache. With this record the pipeline can keep issuing cache accesses while refills are in flight. The cache supplies each lookup result: a valid strobe, a hit or miss flag, the 32-byte line address and the register the load will write. The block holds at most two misses at a time. For each miss it sends a refill request to the second level over a valid/ready handshake. It takes back completion pulses that are tagged with a slot number.

The pipeline sees three outputs. The first is a stall line. It rises only when an access arrives while both slots are taken, or when a source operand names a register whose data a pending miss still owes. The second is a per-register pending mask. The third is the refill request itself. A miss to a line that a slot already tracks joins that slot and uses no second one. Register 0 always reads as zero, so it never becomes pending and never causes a stall.

Top module: `nbmt_tracker`

## Requirements
- R1: After reset both slots are free, `pend_mask` is all zero, and `req_valid` and `stall` are low.
- R2: An accepted miss (`lk_valid`=1, `lk_miss`=1, `stall`=0) whose line is not held by any slot goes into the lowest-numbered free slot. From the next cycle that slot asks for its line on `req_line`, and its number appears on `req_slot`.
- R3: An accepted miss sets the `pend_mask` bit of its destination register from the next cycle on. The bit for register 0 is never set.
- R4: `stall` is high in any cycle where `lk_valid` is high and both slots are busy, for hits and misses alike. A stalled access changes no slot and no pending bit.
- R5: `stall` is high whenever a valid source tag that is not zero names a register whose `pend_mask` bit is set. A source tag of 0 never stalls.
- R6: An accepted miss to a line that a busy slot holds joins that slot. It allocates nothing and adds no request, but it sets its destination bit. The other slot stays free.
- R7: Each slot sends exactly one request. When two slots are waiting, the one allocated earlier goes first. `req_valid`, `req_line` and `req_slot` hold steady until `req_ready` is seen.
- R8: When `fill_valid` names a slot whose request was accepted, that slot becomes free at the next edge. Every pending bit it carried clears at the same edge, unless the other slot also carries that bit.
- R9: A completion that names a slot which is free, or which has not yet had its request accepted, is ignored.
- R10: `stall` is decided from the slot occupancy held at the start of the cycle. A completion in the same cycle does not release an access that arrives while both slots are busy; that access is accepted in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A cache access is presented this cycle |
| lk_miss | input | 1 | The access missed in the primary cache |
| lk_line | input | 27 | Line address (byte address without the low 5 bits) |
| lk_dst | input | 5 | Destination register of the access |
| src0_vld | input | 1 | Source operand 0 is in use |
| src0_tag | input | 5 | Register read by source operand 0 |
| src1_vld | input | 1 | Source operand 1 is in use |
| src1_tag | input | 5 | Register read by source operand 1 |
| stall | output | 1 | Hold the pipeline this cycle |
| pend_mask | output | 32 | One bit per register still owed by a miss |
| req_valid | output | 1 | A refill request is offered |
| req_ready | input | 1 | Second level takes the request |
| req_line | output | 27 | Line address being requested |
| req_slot | output | 1 | Slot that owns the request |
| fill_valid | input | 1 | A refill has completed |
| fill_slot | input | 1 | Slot the completion belongs to |

## Verification
Single isolated misses show where allocation and pending bits land, and show that register 0 is left out. A pair of misses to one line, followed by a miss to a different line, separates merging from allocating. It does so by which slot number the later request carries. Filling both slots, holding `req_ready` low and retiring slots out of order shows whether requests follow age or slot index. The same traffic shows whether a completion that arrives together with a stalled access releases that access early. Hazard tests on each source port, and completions aimed at free or unsent slots, show that only pending destinations stall and that stray completions are ignored.

// File: rtl/nbmt_pkg.sv
package nbmt_pkg;
    localparam int SLOTS  = 2;
    localparam int SLOT_W = 1;

    typedef enum logic [1:0] {
        SL_FREE = 2'd0,
        SL_WANT = 2'd1,
        SL_SENT = 2'd2
    } slot_state_e;
endpackage

// File: rtl/nbmt_slot.sv
module nbmt_slot
    import nbmt_pkg::*;
#(
    parameter int LINE_W = 27,
    parameter int NREG   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [NREG-1:0]   set_i,
    input  logic              sent_i,
    input  logic              fill_i,
    input  logic              peer_alive_i,
    output logic              busy_o,
    output logic              want_o,
    output logic              young_o,
    output logic [LINE_W-1:0] line_o,
    output logic [NREG-1:0]   regs_o
);
    typedef struct packed {
        slot_state_e       st;
        logic [LINE_W-1:0] line;
        logic [NREG-1:0]   regs;
        logic              young;
    } slot_t;

    slot_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (fill_i && cur_q.st == SL_SENT) begin
            nxt_d.st    = SL_FREE;
            nxt_d.regs  = '0;
            nxt_d.young = 1'b0;
        end else if (alloc_i) begin
            nxt_d.st    = SL_WANT;
            nxt_d.line  = line_i;
            nxt_d.regs  = set_i;
            nxt_d.young = peer_alive_i;
        end else begin
            if (sent_i && cur_q.st == SL_WANT) begin
                nxt_d.st = SL_SENT;
            end
            nxt_d.regs = cur_q.regs | set_i;
            if (!peer_alive_i) begin
                nxt_d.young = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: SL_FREE, line: '0, regs: '0, young: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy_o  = (cur_q.st != SL_FREE);
    assign want_o  = (cur_q.st == SL_WANT);
    assign young_o = cur_q.young;
    assign line_o  = cur_q.line;
    assign regs_o  = cur_q.regs;

    // R8
    fill_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && cur_q.st == SL_SENT) |=> (cur_q.st == SL_FREE && cur_q.regs == '0));

    // R8
    free_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == SL_FREE) |-> (cur_q.regs == '0));
endmodule

// File: rtl/nbmt_scoreboard.sv
module nbmt_scoreboard
    import nbmt_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int REG_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SLOTS-1:0][NREG-1:0] regs_i,
    input  logic                       src0_vld,
    input  logic [REG_W-1:0]           src0_tag,
    input  logic                       src1_vld,
    input  logic [REG_W-1:0]           src1_tag,
    output logic [NREG-1:0]            pend_o,
    output logic                       hazard_o
);
    always_comb begin
        pend_o = '0;
        for (int k = 0; k < SLOTS; k++) begin
            pend_o = pend_o | regs_i[k];
        end
        hazard_o = (src0_vld && src0_tag != '0 && pend_o[src0_tag])
                || (src1_vld && src1_tag != '0 && pend_o[src1_tag]);
    end

    // R3
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o[0] == 1'b0);
endmodule

// File: rtl/nbmt_tracker.sv
module nbmt_tracker
    import nbmt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NREG       = 32,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int REG_W     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_miss,
    input  logic [LINE_W-1:0] lk_line,
    input  logic [REG_W-1:0]  lk_dst,
    input  logic              src0_vld,
    input  logic [REG_W-1:0]  src0_tag,
    input  logic              src1_vld,
    input  logic [REG_W-1:0]  src1_tag,
    output logic              stall,
    output logic [NREG-1:0]   pend_mask,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [LINE_W-1:0] req_line,
    output logic [SLOT_W-1:0] req_slot,
    input  logic              fill_valid,
    input  logic [SLOT_W-1:0] fill_slot
);
    logic [SLOTS-1:0]            busy, want, young, alive, fill_take;
    logic [SLOTS-1:0]            line_hit, alloc, sent;
    logic [LINE_W-1:0]           sl_line [SLOTS];
    logic [SLOTS-1:0][NREG-1:0]  sl_regs, set_mask;
    logic [NREG-1:0]             dst_mask;
    logic                        full, hazard, accept, merge_any, found, pick;

    always_comb begin
        full     = &busy;
        stall    = (lk_valid && full) || hazard;
        accept   = lk_valid && lk_miss && !stall;
        dst_mask = '0;
        dst_mask[lk_dst] = 1'b1;
        dst_mask[0] = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            fill_take[k] = fill_valid && (fill_slot == SLOT_W'(k)) && busy[k] && !want[k];
            alive[k]     = busy[k] && !fill_take[k];
            line_hit[k]  = alive[k] && (sl_line[k] == lk_line);
        end
        merge_any = |line_hit;
        alloc = '0;
        found = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            if (!busy[k] && !found) begin
                alloc[k] = accept && !merge_any;
                found    = 1'b1;
            end
        end
        for (int k = 0; k < SLOTS; k++) begin
            set_mask[k] = (alloc[k] || (accept && line_hit[k])) ? dst_mask : '0;
        end
        pick      = (want[0] && want[1]) ? young[0] : want[1];
        req_valid = |want;
        req_slot  = pick;
        req_line  = sl_line[pick];
        for (int k = 0; k < SLOTS; k++) begin
            sent[k] = req_valid && req_ready && (pick == SLOT_W'(k));
        end
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        nbmt_slot #(.LINE_W(LINE_W), .NREG(NREG)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_i      (alloc[k]),
            .line_i       (lk_line),
            .set_i        (set_mask[k]),
            .sent_i       (sent[k]),
            .fill_i       (fill_take[k]),
            .peer_alive_i (alive[SLOTS-1-k]),
            .busy_o       (busy[k]),
            .want_o       (want[k]),
            .young_o      (young[k]),
            .line_o       (sl_line[k]),
            .regs_o       (sl_regs[k])
        );
    end

    nbmt_scoreboard #(.NREG(NREG), .REG_W(REG_W)) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .regs_i   (sl_regs),
        .src0_vld (src0_vld),
        .src0_tag (src0_tag),
        .src1_vld (src1_vld),
        .src1_tag (src1_tag),
        .pend_o   (pend_mask),
        .hazard_o (hazard)
    );

    // R2
    alloc_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|alloc) |=> req_valid);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_line) && $stable(req_slot)));

    // R4
    stall_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !fill_valid) |=> $stable(pend_mask));
endmodule

// File: tb/nbmt_tracker_test.sv
module nbmt_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_miss;
    logic [26:0] lk_line;
    logic [4:0]  lk_dst;
    logic        src0_vld, src1_vld;
    logic [4:0]  src0_tag, src1_tag;
    logic        stall;
    logic [31:0] pend_mask;
    logic        req_valid, req_ready;
    logic [26:0] req_line;
    logic [0:0]  req_slot;
    logic        fill_valid;
    logic [0:0]  fill_slot;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    nbmt_tracker uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_miss(lk_miss), .lk_line(lk_line), .lk_dst(lk_dst),
        .src0_vld(src0_vld), .src0_tag(src0_tag), .src1_vld(src1_vld), .src1_tag(src1_tag),
        .stall(stall), .pend_mask(pend_mask),
        .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line), .req_slot(req_slot),
        .fill_valid(fill_valid), .fill_slot(fill_slot)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        lk_valid = 0; lk_miss = 0; lk_line = '0; lk_dst = '0;
        src0_vld = 0; src0_tag = '0; src1_vld = 0; src1_tag = '0;
        req_ready = 0; fill_valid = 0; fill_slot = '0;
    endtask

    function automatic logic [26:0] line_of(input logic [31:0] a);
        return a[31:5];
    endfunction

    task automatic put_miss(input logic [31:0] a, input logic [4:0] d);
        lk_valid = 1; lk_miss = 1; lk_line = line_of(a); lk_dst = d;
    endtask

    task automatic miss(input logic [31:0] a, input logic [4:0] d);
        put_miss(a, d);
        tick();
        idle();
    endtask

    task automatic send();
        req_ready = 1;
        tick();
        req_ready = 0;
    endtask

    task automatic fill(input logic s);
        fill_valid = 1; fill_slot = s;
        tick();
        fill_valid = 0;
    endtask

    task automatic t_reset();
        check("R1 stall", stall, 0);
        check("R1 pend", pend_mask, 0);
        check("R1 req_valid", req_valid, 0);
    endtask

    task automatic t_alloc();
        put_miss(32'h1234, 5'd3);
        #1 check("R4 no stall with free slot", stall, 0);
        tick(); idle();
        check("R2 req_valid", req_valid, 1);
        check("R2 req_line", req_line, 27'h91);
        check("R2 req_slot", req_slot, 0);
        check("R3 pend bit", pend_mask, 32'h8);
        send();
        check("R7 one request", req_valid, 0);
        fill(0);
        check("R8 pend cleared", pend_mask, 0);
    endtask

    task automatic t_zero();
        miss(32'h4000, 5'd0);
        check("R3 r0 never pending", pend_mask, 0);
        check("R2 r0 miss requests", req_valid, 1);
        src0_vld = 1; src0_tag = 5'd0;
        #1 check("R5 r0 no stall", stall, 0);
        idle();
        send();
        fill(0);
    endtask

    task automatic t_merge();
        miss(32'h2000, 5'd4);
        miss(32'h2010, 5'd6);
        check("R6 both pending", pend_mask, 32'h50);
        check("R6 slot0 line", req_line, 27'h100);
        send();
        check("R6 no second request", req_valid, 0);
        put_miss(32'h3000, 5'd7);
        #1 check("R6 slot still free", stall, 0);
        tick(); idle();
        check("R6 new miss slot1", req_slot, 1);
        send();
        fill(0);
        check("R8 merged bits clear", pend_mask, 32'h80);
        fill(1);
        check("R8 all clear", pend_mask, 0);
    endtask

    task automatic t_full();
        miss(32'h100, 5'd1);
        miss(32'h200, 5'd2);
        lk_valid = 1; lk_miss = 0;
        #1 check("R4 hit stalls when full", stall, 1);
        put_miss(32'h300, 5'd5);
        #1 check("R4 miss stalls when full", stall, 1);
        tick(); idle();
        check("R4 stalled miss ignored", pend_mask, 32'h6);
        check("R7 older first slot", req_slot, 0);
        check("R7 older first line", req_line, 27'h8);
        tick();
        check("R7 held without ready", req_slot, 0);
        send();
        check("R7 second slot", req_slot, 1);
        check("R7 second line", req_line, 27'h10);
        send();
        put_miss(32'h300, 5'd5);
        fill_valid = 1; fill_slot = 0;
        #1 check("R10 fill does not release now", stall, 1);
        tick();
        fill_valid = 0;
        #1 check("R10 released next cycle", stall, 0);
        tick(); idle();
        check("R10 accepted late", pend_mask, 32'h24);
        check("R2 reuse slot0", req_slot, 0);
        check("R2 reuse line", req_line, 27'h18);
        send();
        fill(1);
        fill(0);
        check("R8 full drained", pend_mask, 0);
    endtask

    task automatic t_order();
        miss(32'h1000, 5'd8);
        send();
        miss(32'h1100, 5'd9);
        fill(0);
        miss(32'h1200, 5'd11);
        check("R7 age beats index slot", req_slot, 1);
        check("R7 age beats index line", req_line, 27'h88);
        send();
        check("R7 younger next slot", req_slot, 0);
        check("R7 younger next line", req_line, 27'h90);
        send();
        fill(1);
        fill(0);
        check("R8 order drained", pend_mask, 0);
    endtask

    task automatic t_hazard();
        miss(32'h5000, 5'd9);
        src0_vld = 1; src0_tag = 5'd9;
        #1 check("R5 src0 hazard", stall, 1);
        src0_vld = 0; src1_vld = 1; src1_tag = 5'd9;
        #1 check("R5 src1 hazard", stall, 1);
        src1_tag = 5'd8;
        #1 check("R5 other reg no stall", stall, 0);
        idle();
        send();
        fill(0);
        src0_vld = 1; src0_tag = 5'd9;
        #1 check("R5 cleared after fill", stall, 0);
        idle();
    endtask

    task automatic t_badfill();
        miss(32'h6000, 5'd10);
        fill(0);
        check("R9 unsent fill ignored pend", pend_mask, 32'h400);
        check("R9 unsent fill ignored req", req_valid, 1);
        fill(1);
        check("R9 free slot fill ignored", pend_mask, 32'h400);
        send();
        fill(0);
        check("R8 after real fill", pend_mask, 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        #1;
        t_reset();
        t_alloc();
        t_zero();
        t_merge();
        t_full();
        t_order();
        t_hazard();
        t_badfill();
        finish_run();
    end
endmodule